// File: doc/BRIEF.md
# Base-Limit Address Relocation Unit

This unit relocates and bounds-checks every memory reference made by a running process. It holds two independent relocation windows, one for instruction fetches and one for data operand accesses. Each window is a base and a limit. A request carries a logical address and a flag that says whether it is a fetch. The unit adds the base of the selected window to the logical address, which gives the physical address. It then checks that physical address against the limit of the same window.

An access that leaves its window is blocked, so its memory strobe stays low. It raises one of two range exceptions: one for fetches and one for operands. The faulting logical address is reported with the exception. There is no translation cache, so every reference pays for the add and the compare. Protection covers bounds only; there are no per-page access rights.

The window registers can be written only in supervisor mode. A write made in user mode changes nothing and raises a privilege error. Results are registered and appear one cycle after each request.

Top module: `blr_unit`

## Requirements
- R1: While rst_ni is low and after its release, all four window registers read as zero and every output is low or zero; with limit zero, every request faults.
- R2: When cfg_we_i and sup_mode_i are both high, cfg_wdata_i is stored in the register chosen by cfg_sel_i (0 = fetch base, 1 = fetch limit, 2 = data base, 3 = data limit). The new value applies to requests issued from the next cycle on.
- R3: When cfg_we_i is high and sup_mode_i is low, no register changes, and cfg_priv_err_o is high for exactly the following cycle.
- R4: rsp_paddr_o equals the base of the selected window plus the logical address, truncated to ADDR_W bits. A request with req_is_fetch_i = 1 uses the fetch window; one with 0 uses the data window.
- R5: An access is in range only when the physical address is at or above the base and strictly below the limit. A physical address equal to the limit is out of range.
- R6: An out-of-range fetch raises fetch_range_exc_o. An out-of-range data access raises operand_range_exc_o. The two flags are never high together.
- R7: rsp_valid_o and the other result outputs appear exactly one cycle after req_valid_i is sampled high, and every request is accepted.
- R8: When either exception is raised, mem_strobe_o is low and fault_laddr_o carries the request's logical address. Otherwise fault_laddr_o is zero and mem_strobe_o equals rsp_valid_o.
- R9: A carry out of the base-plus-logical addition makes the access out of range, even when the truncated sum lies below the limit.
- R10: A request in the same cycle as a register write is translated with the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sup_mode_i | input | 1 | Supervisor mode; gates register writes |
| cfg_we_i | input | 1 | Window register write strobe |
| cfg_sel_i | input | 2 | Register select: 0 fetch base, 1 fetch limit, 2 data base, 3 data limit |
| cfg_wdata_i | input | ADDR_W | Write data |
| cfg_priv_err_o | output | 1 | User-mode write attempt, one cycle after the write |
| req_valid_i | input | 1 | Request valid |
| req_is_fetch_i | input | 1 | 1 = instruction fetch, 0 = data operand |
| req_laddr_i | input | ADDR_W | Logical address from the program |
| rsp_valid_o | output | 1 | Result valid |
| mem_strobe_o | output | 1 | Memory access strobe, low on any fault |
| rsp_paddr_o | output | ADDR_W | Relocated physical address |
| fetch_range_exc_o | output | 1 | Fetch outside the fetch window |
| operand_range_exc_o | output | 1 | Data access outside the data window |
| fault_laddr_o | output | ADDR_W | Logical address of the faulting request |

## Verification
Two functions can fall in the same cycle: a window register write and a request that reads that window. The bench places a supervisor write to the fetch base in the same cycle as a fetch request. The result must show the old base. A follow-up request must show the new base, and because the new base lies above the fetch limit, that request must fault. User-mode writes are judged through later requests: the limit they tried to raise must still cause a fault.

// File: rtl/blr_pkg.sv
package blr_pkg;
  parameter int unsigned ADDR_W_DEF = 24;
  localparam int unsigned NUM_REGS = 4;

  typedef enum logic [1:0] {
    SEL_FETCH_BASE  = 2'd0,
    SEL_FETCH_LIMIT = 2'd1,
    SEL_DATA_BASE   = 2'd2,
    SEL_DATA_LIMIT  = 2'd3
  } win_sel_e;
endpackage

// File: rtl/blr_bank.sv
module blr_bank #(
  parameter int unsigned ADDR_W = blr_pkg::ADDR_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sup_mode_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  output logic              priv_err_o,
  output logic [ADDR_W-1:0] fetch_base_o,
  output logic [ADDR_W-1:0] fetch_limit_o,
  output logic [ADDR_W-1:0] data_base_o,
  output logic [ADDR_W-1:0] data_limit_o
);
  import blr_pkg::*;

  logic [NUM_REGS-1:0][ADDR_W-1:0] regs_q;
  logic                            wr_ok;

  assign wr_ok = cfg_we_i && sup_mode_i;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                regs_q[g] <= '0;
      else if (wr_ok && (cfg_sel_i == 2'(g)))     regs_q[g] <= cfg_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) priv_err_o <= 1'b0;
    else         priv_err_o <= cfg_we_i && !sup_mode_i;
  end

  assign fetch_base_o  = regs_q[SEL_FETCH_BASE];
  assign fetch_limit_o = regs_q[SEL_FETCH_LIMIT];
  assign data_base_o   = regs_q[SEL_DATA_BASE];
  assign data_limit_o  = regs_q[SEL_DATA_LIMIT];

  // R3: user-mode writes leave the bank untouched
  assert_user_write_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !sup_mode_i) |=> $stable(regs_q));
  assert_priv_err_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !sup_mode_i) |=> priv_err_o);
  // R2: supervisor write lands in the selected register
  assert_sup_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> regs_q[$past(cfg_sel_i)] == $past(cfg_wdata_i));
endmodule

// File: rtl/blr_check.sv
module blr_check #(
  parameter int unsigned ADDR_W = blr_pkg::ADDR_W_DEF
) (
  input  logic              is_fetch_i,
  input  logic [ADDR_W-1:0] laddr_i,
  input  logic [ADDR_W-1:0] fetch_base_i,
  input  logic [ADDR_W-1:0] fetch_limit_i,
  input  logic [ADDR_W-1:0] data_base_i,
  input  logic [ADDR_W-1:0] data_limit_i,
  output logic [ADDR_W-1:0] paddr_o,
  output logic              in_range_o
);
  localparam int unsigned SUM_W = ADDR_W + 1;

  logic [ADDR_W-1:0] base, limit;
  logic [SUM_W-1:0]  sum;
  logic              carry;

  always_comb begin
    base  = is_fetch_i ? fetch_base_i  : data_base_i;
    limit = is_fetch_i ? fetch_limit_i : data_limit_i;
    sum   = {1'b0, base} + {1'b0, laddr_i};
    carry = sum[ADDR_W];
    paddr_o = sum[ADDR_W-1:0];
    // bound is tested on the relocated address
    in_range_o = !carry && (paddr_o >= base) && (paddr_o < limit);
  end
endmodule

// File: rtl/blr_stage.sv
module blr_stage #(
  parameter int unsigned ADDR_W = blr_pkg::ADDR_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              is_fetch_i,
  input  logic [ADDR_W-1:0] laddr_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic              in_range_i,
  output logic              valid_o,
  output logic              strobe_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic              fetch_exc_o,
  output logic              oper_exc_o,
  output logic [ADDR_W-1:0] fault_laddr_o
);
  logic              valid_q, fetch_q, ok_q;
  logic [ADDR_W-1:0] paddr_q, laddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      fetch_q <= 1'b0;
      ok_q    <= 1'b0;
      paddr_q <= '0;
      laddr_q <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        fetch_q <= is_fetch_i;
        ok_q    <= in_range_i;
        paddr_q <= paddr_i;
        laddr_q <= laddr_i;
      end
    end
  end

  logic fault;
  assign fault         = valid_q && !ok_q;
  assign valid_o       = valid_q;
  assign strobe_o      = valid_q && ok_q;
  assign paddr_o       = valid_q ? paddr_q : '0;
  assign fetch_exc_o   = fault && fetch_q;
  assign oper_exc_o    = fault && !fetch_q;
  assign fault_laddr_o = fault ? laddr_q : '0;

  assert_result_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_fault_laddr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !in_range_i) |=> (fault_laddr_o == $past(laddr_i)) && !strobe_o);
  assert_exc_kind_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !in_range_i && is_fetch_i) |=> fetch_exc_o && !oper_exc_o);
endmodule

// File: rtl/blr_unit.sv
module blr_unit #(
  parameter int unsigned ADDR_W = blr_pkg::ADDR_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sup_mode_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  output logic              cfg_priv_err_o,
  input  logic              req_valid_i,
  input  logic              req_is_fetch_i,
  input  logic [ADDR_W-1:0] req_laddr_i,
  output logic              rsp_valid_o,
  output logic              mem_strobe_o,
  output logic [ADDR_W-1:0] rsp_paddr_o,
  output logic              fetch_range_exc_o,
  output logic              operand_range_exc_o,
  output logic [ADDR_W-1:0] fault_laddr_o
);
  logic [ADDR_W-1:0] fetch_base, fetch_limit, data_base, data_limit;
  logic [ADDR_W-1:0] paddr;
  logic              in_range;

  blr_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk_i, .rst_ni, .sup_mode_i, .cfg_we_i, .cfg_sel_i, .cfg_wdata_i,
    .priv_err_o   (cfg_priv_err_o),
    .fetch_base_o (fetch_base),
    .fetch_limit_o(fetch_limit),
    .data_base_o  (data_base),
    .data_limit_o (data_limit)
  );

  blr_check #(.ADDR_W(ADDR_W)) u_check (
    .is_fetch_i   (req_is_fetch_i),
    .laddr_i      (req_laddr_i),
    .fetch_base_i (fetch_base),
    .fetch_limit_i(fetch_limit),
    .data_base_i  (data_base),
    .data_limit_i (data_limit),
    .paddr_o      (paddr),
    .in_range_o   (in_range)
  );

  blr_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk_i, .rst_ni,
    .valid_i      (req_valid_i),
    .is_fetch_i   (req_is_fetch_i),
    .laddr_i      (req_laddr_i),
    .paddr_i      (paddr),
    .in_range_i   (in_range),
    .valid_o      (rsp_valid_o),
    .strobe_o     (mem_strobe_o),
    .paddr_o      (rsp_paddr_o),
    .fetch_exc_o  (fetch_range_exc_o),
    .oper_exc_o   (operand_range_exc_o),
    .fault_laddr_o(fault_laddr_o)
  );

  assert_exc_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fetch_range_exc_o, operand_range_exc_o}));
  assert_no_strobe_on_fault_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_strobe_o |-> !(fetch_range_exc_o || operand_range_exc_o));
  assert_strobe_needs_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_strobe_o |-> rsp_valid_o);
endmodule

// File: tb/blr_unit_test.sv
module blr_unit_test;
  localparam int unsigned AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sup, we, is_fetch, req_v;
  logic [1:0]    sel;
  logic [AW-1:0] wdata, laddr;
  logic          priv_err, rsp_v, strobe, f_exc, o_exc;
  logic [AW-1:0] paddr, fladdr;

  int checks = 0, fails = 0;
  logic [AW-1:0] m_fb = '0, m_fl = '0, m_db = '0, m_dl = '0;

  always #2 clk = ~clk;  // 250 MHz

  blr_unit #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sup_mode_i(sup), .cfg_we_i(we), .cfg_sel_i(sel),
    .cfg_wdata_i(wdata), .cfg_priv_err_o(priv_err), .req_valid_i(req_v),
    .req_is_fetch_i(is_fetch), .req_laddr_i(laddr), .rsp_valid_o(rsp_v),
    .mem_strobe_o(strobe), .rsp_paddr_o(paddr), .fetch_range_exc_o(f_exc),
    .operand_range_exc_o(o_exc), .fault_laddr_o(fladdr)
  );

  task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // update bench model after a supervisor write
  task automatic model_wr(logic [1:0] s, logic [AW-1:0] d);
    case (s)
      2'd0: m_fb = d;
      2'd1: m_fl = d;
      2'd2: m_db = d;
      default: m_dl = d;
    endcase
  endtask

  task automatic cfg_write(logic s_mode, logic [1:0] s, logic [AW-1:0] d);
    @(negedge clk);
    sup = s_mode; we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0; sup = 1'b0;
    if (s_mode) model_wr(s, d);
    chk(s_mode ? "R2 no priv err" : "R3 priv err", {23'd0, priv_err}, {23'd0, !s_mode});
  endtask

  // issue a request and check all result ports one cycle later
  task automatic req_check(string tag, logic f, logic [AW-1:0] la);
    logic [AW:0]   sum;
    logic [AW-1:0] b, l;
    logic          ok;
    b = f ? m_fb : m_db;
    l = f ? m_fl : m_dl;
    sum = {1'b0, b} + {1'b0, la};
    ok = !sum[AW] && (sum[AW-1:0] < l) && (sum[AW-1:0] >= b);
    @(negedge clk);
    req_v = 1'b1; is_fetch = f; laddr = la;
    @(negedge clk);
    req_v = 1'b0;
    chk({tag, " R7 valid"}, {23'd0, rsp_v}, 24'd1);
    chk({tag, " R4 paddr"}, paddr, sum[AW-1:0]);
    chk({tag, " R8 strobe"}, {23'd0, strobe}, {23'd0, ok});
    chk({tag, " R6 fetch exc"}, {23'd0, f_exc}, {23'd0, !ok && f});
    chk({tag, " R6 operand exc"}, {23'd0, o_exc}, {23'd0, !ok && !f});
    chk({tag, " R8 fault laddr"}, fladdr, ok ? '0 : la);
  endtask

  task automatic t_reset;
    chk("R1 valid", {23'd0, rsp_v}, '0);
    chk("R1 strobe", {23'd0, strobe}, '0);
    chk("R1 exc", {22'd0, f_exc, o_exc}, '0);
    chk("R1 priv", {23'd0, priv_err}, '0);
    req_check("R1 zero window", 1'b1, 24'h000010);
  endtask

  task automatic t_setup;
    cfg_write(1'b1, 2'd0, 24'h001000);
    cfg_write(1'b1, 2'd1, 24'h002000);
    cfg_write(1'b1, 2'd2, 24'h100000);
    cfg_write(1'b1, 2'd3, 24'h180000);
    req_check("R2 fetch legal", 1'b1, 24'h000010);
    req_check("R2 data legal", 1'b0, 24'h000010);
  endtask

  task automatic t_bounds;
    req_check("R5 fetch limit-1", 1'b1, 24'h000FFF);
    req_check("R5 fetch at limit", 1'b1, 24'h001000);
    req_check("R5 data limit-1", 1'b0, 24'h07FFFF);
    req_check("R5 data at limit", 1'b0, 24'h080000);
    req_check("R6 data far", 1'b0, 24'h300000);
  endtask

  task automatic t_carry;
    cfg_write(1'b1, 2'd2, 24'hF00000);
    cfg_write(1'b1, 2'd3, 24'hFFFFFF);
    req_check("R9 no carry", 1'b0, 24'h0FFFFE);
    req_check("R9 carry", 1'b0, 24'h200000);
  endtask

  task automatic t_user_write;
    cfg_write(1'b0, 2'd1, 24'hFFFFFF);
    @(negedge clk);
    chk("R3 priv err one cycle", {23'd0, priv_err}, '0);
    req_check("R3 limit unchanged", 1'b1, 24'h001000);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    sup = 1'b1; we = 1'b1; sel = 2'd0; wdata = 24'h005000;
    req_v = 1'b1; is_fetch = 1'b1; laddr = 24'h000010;
    @(negedge clk);
    we = 1'b0; sup = 1'b0; req_v = 1'b0;
    chk("R10 old base used", paddr, 24'h001010);
    chk("R10 old window legal", {23'd0, strobe}, 24'd1);
    model_wr(2'd0, 24'h005000);
    req_check("R10 new base", 1'b1, 24'h000010);
  endtask

  initial begin
    sup = 0; we = 0; sel = 0; wdata = 0; req_v = 0; is_fetch = 0; laddr = 0;
    repeat (3) @(negedge clk);
    t_reset_pre: begin
      chk("R1 in reset valid", {23'd0, rsp_v}, '0);
    end
    rst_n = 1'b1;
    t_reset();
    t_setup();
    t_bounds();
    t_carry();
    t_user_write();
    t_same_cycle();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule